// File: doc/BRIEF.md
# Program Counter and Return-Address Stack Unit

This block owns the fetch address of a small 8-bit processor whose instructions are a one-byte opcode followed by zero, one or two operand bytes. The decoder sends one command per cycle on a one-hot bus, together with the length of the current instruction. The block either advances the counter past that instruction, loads a target address built from the two operand bytes, saves a return address and branches, restores a saved address, or vectors to one of eight fixed restart locations.

Jump, call and return each have a conditional form. The decoder marks the command as conditional and supplies the evaluated condition. When the condition is false, the command only steps past the instruction. Return addresses live in a seven-entry circular stack inside the block, not in data memory. Running the stack past either end never stalls the block. It raises a sticky error flag instead.

Top module: `flowctl_unit`

## Requirements
- R1: A step command (cmd bit 0) sets the counter to counter + len_i, where len_i is 0 to 3. The sum wraps modulo 2^14.
- R2: A jump (cmd bit 1) loads the counter with {opd_hi_i[5:0], opd_lo_i}. Bits 7:6 of opd_hi_i have no effect.
- R3: A call (cmd bit 2) pushes counter + len_i onto the stack and loads the counter the same way as a jump.
- R4: A return (cmd bit 3) loads the counter with the most recently pushed entry that has not yet been popped.
- R5: A restart (cmd bit 4) pushes counter + len_i and loads the counter with vec_i × 8. It acts whatever the values of is_cond_i and cond_true_i.
- R6: A jump, call or return with is_cond_i = 1 and cond_true_i = 0 only advances the counter by len_i. It leaves the stack untouched.
- R7: A command bus that is not exactly one-hot (zero, or more than one bit set) changes neither the counter nor the stack.
- R8: The stack holds 7 entries in a circular buffer. The 8th push without a pop overwrites the oldest entry. A pop from an empty stack reads the entry below the pointer with wrap-around. Either event sets stk_err_o, which stays set until reset.
- R9: Reset is synchronous and active low. It clears the counter, every stack entry, the stack pointer and stk_err_o to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 5 | One-hot command: bit 0 step, bit 1 jump, bit 2 call, bit 3 return, bit 4 restart |
| is_cond_i | input | 1 | Marks jump/call/return as conditional |
| cond_true_i | input | 1 | Evaluated condition for a conditional command |
| len_i | input | 2 | Byte length of the current instruction |
| opd_lo_i | input | 8 | Low operand byte of the target |
| opd_hi_i | input | 8 | High operand byte of the target |
| vec_i | input | 3 | Restart vector number |
| pc_o | output | 14 | Program counter |
| stk_err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench builds the block with its default values: a 14-bit counter and a 7-entry stack. With only seven entries, eight nested calls reach overwrite of the oldest return address, and one further return reaches the wrapped underflow read. The 14-bit width lets a jump to the last address followed by a two-byte step show the counter wrapping. Operand bytes with their top bits set show those bits being dropped.

// File: rtl/flowctl_pkg.sv
// Shared constants for the flow-control unit: command bit positions.
// Assumes the command bus is one-hot, one bit per command kind.
package flowctl_pkg;
    localparam int CMD_W  = 5;
    localparam int C_STEP = 0;
    localparam int C_JUMP = 1;
    localparam int C_CALL = 2;
    localparam int C_RET  = 3;
    localparam int C_RSTV = 4;

    typedef struct packed {
        logic adv;   // counter <= counter + len
        logic load;  // counter <= operand target
        logic push;  // save counter + len
        logic pop;   // counter <= top of stack
        logic vect;  // counter <= vec * 8
    } act_t;
endpackage

// File: rtl/flowctl_decode.sv
// Turns the one-hot command and the condition into action strobes.
// Assumes nothing about the inputs: a bus that is not one-hot gives no action.
module flowctl_decode
    import flowctl_pkg::*;
(
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             is_cond_i,
    input  logic             cond_true_i,
    output act_t             act_o
);
    logic legal;
    logic taken;
    logic branchy;

    // Resolve legality, the condition, and the resulting action set
    always_comb begin
        legal   = ($countones(cmd_i) == 1);
        taken   = !is_cond_i || cond_true_i;
        branchy = cmd_i[C_JUMP] || cmd_i[C_CALL] || cmd_i[C_RET];
        act_o.adv  = legal && (cmd_i[C_STEP] || (branchy && !taken));
        act_o.load = legal && (cmd_i[C_JUMP] || cmd_i[C_CALL]) && taken;
        act_o.push = legal && ((cmd_i[C_CALL] && taken) || cmd_i[C_RSTV]);
        act_o.pop  = legal && cmd_i[C_RET] && taken;
        act_o.vect = legal && cmd_i[C_RSTV];
    end
endmodule

// File: rtl/flowctl_ras.sv
// Circular return-address stack of DEPTH entries with a sticky error flag.
// Assumes push and pop are never asserted in the same cycle.
module flowctl_ras #(
    parameter int DEPTH = 7,
    parameter int AW    = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] wdata_i,
    output logic [AW-1:0] rdata_o,
    output logic          err_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [AW-1:0] mem_q [DEPTH];
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ptr_inc;
    logic [PW-1:0] ptr_dec;
    logic [CW-1:0] cnt_q;
    logic          err_q;

    // Neighbouring pointer positions with wrap-around
    always_comb begin
        ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + PW'(1);
        ptr_dec = (ptr_q == '0) ? LAST : ptr_q - PW'(1);
        rdata_o = mem_q[ptr_dec];
    end

    // Entry storage, one register slot per stack position
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem_q[g] <= '0;
            else if (push_i && ptr_q == PW'(g))
                mem_q[g] <= wdata_i;
        end
    end

    // Pointer, occupancy and sticky error tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            cnt_q <= '0;
            err_q <= 1'b0;
        end else if (push_i) begin
            ptr_q <= ptr_inc;
            if (cnt_q == FULL) err_q <= 1'b1;
            else               cnt_q <= cnt_q + CW'(1);
        end else if (pop_i) begin
            ptr_q <= ptr_dec;
            if (cnt_q == '0) err_q <= 1'b1;
            else             cnt_q <= cnt_q - CW'(1);
        end
    end

    assign err_o = err_q;
endmodule

// File: rtl/flowctl_unit.sv
// Program counter with jump, call, return and restart-vector handling.
// Assumes len_i gives the full byte length of the instruction being executed.
module flowctl_unit
    import flowctl_pkg::*;
#(
    parameter int PC_W  = 14,
    parameter int DEPTH = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_W-1:0] cmd_i,
    input  logic             is_cond_i,
    input  logic             cond_true_i,
    input  logic [1:0]       len_i,
    input  logic [7:0]       opd_lo_i,
    input  logic [7:0]       opd_hi_i,
    input  logic [2:0]       vec_i,
    output logic [PC_W-1:0]  pc_o,
    output logic             stk_err_o
);
    act_t            act;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] seq_addr;
    logic [PC_W-1:0] tgt_addr;
    logic [PC_W-1:0] vec_addr;
    logic [PC_W-1:0] pop_addr;
    logic [15:0]     opd_word;

    flowctl_decode u_dec (
        .cmd_i       (cmd_i),
        .is_cond_i   (is_cond_i),
        .cond_true_i (cond_true_i),
        .act_o       (act)
    );

    flowctl_ras #(.DEPTH(DEPTH), .AW(PC_W)) u_ras (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_i  (act.push),
        .pop_i   (act.pop),
        .wdata_i (seq_addr),
        .rdata_o (pop_addr),
        .err_o   (stk_err_o)
    );

    // Candidate next addresses
    always_comb begin
        opd_word = {opd_hi_i, opd_lo_i};
        seq_addr = pc_q + PC_W'(len_i);
        tgt_addr = opd_word[PC_W-1:0];
        vec_addr = PC_W'({vec_i, 3'b000});
    end

    // Counter update, one action at most per cycle
    always_ff @(posedge clk) begin
        if (!rst_n)        pc_q <= '0;
        else if (act.adv)  pc_q <= seq_addr;
        else if (act.load) pc_q <= tgt_addr;
        else if (act.pop)  pc_q <= pop_addr;
        else if (act.vect) pc_q <= vec_addr;
    end

    assign pc_o = pc_q;
endmodule

// File: rtl/flowctl_chk.sv
// Property checker for flowctl_unit, attached by bind.
module flowctl_chk #(
    parameter int PC_W = 14
) (
    input logic            clk,
    input logic            rst_n,
    input logic [4:0]      cmd_i,
    input logic            is_cond_i,
    input logic            cond_true_i,
    input logic [1:0]      len_i,
    input logic [7:0]      opd_lo_i,
    input logic [7:0]      opd_hi_i,
    input logic [2:0]      vec_i,
    input logic [PC_W-1:0] pc_o,
    input logic            stk_err_o
);
    p_reset_r9: assert property (@(posedge clk) $rose(rst_n) |-> (pc_o == '0 && !stk_err_o));

    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 5'b00001) |=> (pc_o == PC_W'($past(pc_o) + PC_W'($past(len_i)))));

    p_jump_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 5'b00010 && (!is_cond_i || cond_true_i))
        |=> (pc_o == PC_W'({$past(opd_hi_i), $past(opd_lo_i)})));

    p_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 5'b10000) |=> (pc_o == PC_W'({$past(vec_i), 3'b000})));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cmd_i) != 1) |=> $stable(pc_o));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stk_err_o |=> stk_err_o);
endmodule

bind flowctl_unit flowctl_chk #(.PC_W(PC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .is_cond_i(is_cond_i),
    .cond_true_i(cond_true_i), .len_i(len_i), .opd_lo_i(opd_lo_i),
    .opd_hi_i(opd_hi_i), .vec_i(vec_i), .pc_o(pc_o), .stk_err_o(stk_err_o)
);

// File: tb/sim_flowctl_unit.sv
module sim_flowctl_unit;
    localparam logic [4:0] STEP = 5'b00001;
    localparam logic [4:0] JMP  = 5'b00010;
    localparam logic [4:0] CALL = 5'b00100;
    localparam logic [4:0] RET  = 5'b01000;
    localparam logic [4:0] RSTV = 5'b10000;

    typedef struct packed {
        logic [4:0]  cmd;
        logic        cnd;
        logic        ct;
        logic [1:0]  len;
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic [2:0]  vec;
        logic [13:0] pc;
        logic        err;
    } row_t;

    localparam int NROW = 17;
    localparam row_t TBL [NROW] = '{
        '{STEP,    1'b0, 1'b0, 2'd1, 8'h00, 8'h00, 3'd0, 14'h0001, 1'b0}, // R1
        '{STEP,    1'b0, 1'b0, 2'd3, 8'h00, 8'h00, 3'd0, 14'h0004, 1'b0}, // R1
        '{JMP,     1'b0, 1'b0, 2'd3, 8'h34, 8'hC2, 3'd0, 14'h0234, 1'b0}, // R2 top bits dropped
        '{JMP,     1'b1, 1'b0, 2'd3, 8'hFF, 8'h3F, 3'd0, 14'h0237, 1'b0}, // R6
        '{CALL,    1'b0, 1'b0, 2'd3, 8'h00, 8'h10, 3'd0, 14'h1000, 1'b0}, // R3
        '{CALL,    1'b1, 1'b1, 2'd3, 8'h80, 8'h05, 3'd0, 14'h0580, 1'b0}, // R3
        '{RSTV,    1'b0, 1'b0, 2'd1, 8'h00, 8'h00, 3'd5, 14'h0028, 1'b0}, // R5
        '{RET,     1'b1, 1'b0, 2'd1, 8'h00, 8'h00, 3'd0, 14'h0029, 1'b0}, // R6
        '{RET,     1'b0, 1'b0, 2'd1, 8'h00, 8'h00, 3'd0, 14'h0581, 1'b0}, // R4
        '{RET,     1'b1, 1'b1, 2'd1, 8'h00, 8'h00, 3'd0, 14'h1003, 1'b0}, // R4
        '{5'b00110,1'b0, 1'b0, 2'd1, 8'h11, 8'h22, 3'd0, 14'h1003, 1'b0}, // R7
        '{5'b00000,1'b0, 1'b0, 2'd1, 8'h00, 8'h00, 3'd0, 14'h1003, 1'b0}, // R7
        '{RET,     1'b0, 1'b0, 2'd1, 8'h00, 8'h00, 3'd0, 14'h023A, 1'b0}, // R4/R7 no push
        '{RSTV,    1'b1, 1'b0, 2'd1, 8'h00, 8'h00, 3'd7, 14'h0038, 1'b0}, // R5 cond ignored
        '{RET,     1'b0, 1'b0, 2'd1, 8'h00, 8'h00, 3'd0, 14'h023B, 1'b0}, // R4
        '{CALL,    1'b1, 1'b0, 2'd3, 8'h00, 8'h20, 3'd0, 14'h023E, 1'b0}, // R6
        '{RET,     1'b0, 1'b0, 2'd1, 8'h00, 8'h00, 3'd0, 14'h0000, 1'b1}  // R8 underflow
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cmd_i = '0;
    logic        is_cond_i = 1'b0;
    logic        cond_true_i = 1'b0;
    logic [1:0]  len_i = '0;
    logic [7:0]  opd_lo_i = '0;
    logic [7:0]  opd_hi_i = '0;
    logic [2:0]  vec_i = '0;
    logic [13:0] pc_o;
    logic        stk_err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    flowctl_unit u0 (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .is_cond_i(is_cond_i),
        .cond_true_i(cond_true_i), .len_i(len_i), .opd_lo_i(opd_lo_i),
        .opd_hi_i(opd_hi_i), .vec_i(vec_i), .pc_o(pc_o), .stk_err_o(stk_err_o)
    );

    task automatic check(input string req, input logic [13:0] epc, input logic eerr);
        n_chk++;
        if (pc_o !== epc || stk_err_o !== eerr) begin
            n_bad++;
            $display("FAIL %s: pc=%h err=%b expected pc=%h err=%b", req, pc_o, stk_err_o, epc, eerr);
        end
    endtask

    task automatic drive(input logic [4:0] c, input logic cnd, input logic ct,
                         input logic [1:0] ln, input logic [7:0] lo, input logic [7:0] hi,
                         input logic [2:0] vc);
        @(negedge clk);
        cmd_i = c; is_cond_i = cnd; cond_true_i = ct; len_i = ln;
        opd_lo_i = lo; opd_hi_i = hi; vec_i = vc;
        @(posedge clk);
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_i = STEP; len_i = 2'd1;
        @(posedge clk);
        #2;
        @(negedge clk);
        rst_n = 1'b1; cmd_i = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        check("R9 reset state", 14'h0000, 1'b0);

        for (int i = 0; i < NROW; i++) begin
            drive(TBL[i].cmd, TBL[i].cnd, TBL[i].ct, TBL[i].len,
                  TBL[i].lo, TBL[i].hi, TBL[i].vec);
            check($sformatf("table row %0d (R1-R8 group)", i), TBL[i].pc, TBL[i].err);
        end

        // R9: reset while running clears the counter and the sticky flag
        do_reset();
        check("R9 reset clears err", 14'h0000, 1'b0);

        // R8: eight nested calls overflow; the 8th push overwrites the oldest
        for (int k = 0; k < 8; k++) begin
            drive(CALL, 1'b0, 1'b0, 2'd3, 8'h00, 8'(k + 1), 3'd0);
            check("R3 nested call", 14'((k + 1) * 256), (k == 7));
        end
        for (int k = 1; k <= 7; k++) begin
            drive(RET, 1'b0, 1'b0, 2'd1, 8'h00, 8'h00, 3'd0);
            check("R4 nested return", 14'((8 - k) * 256 + 3), 1'b1);
        end
        drive(RET, 1'b0, 1'b0, 2'd1, 8'h00, 8'h00, 3'd0);
        check("R8 wrapped pop", 14'h0703, 1'b1);

        // R1: counter wraps at 2^14, zero length holds
        do_reset();
        drive(JMP, 1'b0, 1'b0, 2'd3, 8'hFF, 8'hFF, 3'd0);
        check("R2 jump to last address", 14'h3FFF, 1'b0);
        drive(STEP, 1'b0, 1'b0, 2'd2, 8'h00, 8'h00, 3'd0);
        check("R1 wrap", 14'h0001, 1'b0);
        drive(STEP, 1'b0, 1'b0, 2'd0, 8'h00, 8'h00, 3'd0);
        check("R1 zero length", 14'h0001, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule